// File: doc/BRIEF.md
# Restart-Vector Interrupt Responder

This block sits on the peripheral side of an 8-bit processor bus and gathers up to eight device interrupt request lines. Each rising edge on a request line, once synchronized into the local clock domain, sets a pending bit. Whenever a pending source is not blocked by the mask register, the block pulls the shared active-low interrupt line to the CPU low. It only ever pulls that line low or lets go of it, so several such units can share one line with a pull-up.

The CPU answers with an active-low acknowledge strobe that has memory-read timing. While the strobe is low, the block drives a complete restart opcode for the winning source onto the data bus. Source n produces the opcode for restart n, and the CPU then jumps to vector address n×8. The winning level is fixed at the falling edge of the strobe. When the strobe rises, the pending bit of that level is cleared. Control pins are plain strobes and levels with no handshake. The data bus is shown as an output-enable plus a data value, so the chip's pad ring provides the tri-state buffer.

Top module: `rst_vec_responder`

## Requirements
- R1: After reset `irq_pull_low` is 0, `bus_oe` is 0, the mask is all zeros (every source enabled) and no source is pending.
- R2: A 0-to-1 transition on `dev_req[n]` sets pending bit n within 4 clock edges. A request held high sets it only once: after that bit is cleared, a level that stays high does not set it again.
- R3: `irq_pull_low` is 1 exactly when at least one pending source has its mask bit at 0 (a mask bit of 1 blocks that source).
- R4: A pending source that is masked keeps its pending bit. Once its mask bit is cleared, it raises `irq_pull_low` again.
- R5: When `mask_we` is 1 on a clock edge, `mask_din` is loaded into the mask. The new mask takes effect on `irq_pull_low` and on the selection right after that edge.
- R6: When several unmasked sources are pending, the one with the highest index wins.
- R7: The opcode driven for level n is binary 11_nnn_111, so level 0 gives 0xC7, level 5 gives 0xEF and level 7 gives 0xFF.
- R8: `bus_oe` is 1 while `ack_n` is 0 and 0 while `ack_n` is 1.
- R9: The opcode stays the same for the whole strobe, even if a higher-priority request becomes pending during it.
- R10: One clock edge after `ack_n` rises, only the pending bit of the acknowledged level is cleared. Other pending bits remain.
- R11: An acknowledge that arrives with no unmasked source pending drives 0xFF and clears no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | 8 | Device request lines, asynchronous, rising-edge sensitive |
| mask_we | input | 1 | Mask write strobe |
| mask_din | input | 8 | New mask value; bit n = 1 blocks source n |
| ack_n | input | 1 | Active-low interrupt acknowledge strobe |
| irq_pull_low | output | 1 | 1 = pull the shared interrupt line low, 0 = release it |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 8 | Restart opcode for the data bus |

## Verification
The hardest case to reach is a higher-priority request that becomes pending in the middle of an acknowledge strobe. The bench starts a strobe on a lower level and then raises source 7 while the strobe is held low. It holds the strobe for longer than the synchronizer delay and checks that the bus value does not change. After the strobe ends, the late request must still be pending and must win the next acknowledge. A masked source that is left pending and later unmasked covers the other state that is hard to see from the ports.

// File: rtl/rvr_pkg.sv
package rvr_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic [7:0] restart_op(lvl_t lvl);
    return {2'b11, lvl, 3'b111};
  endfunction
endpackage

// File: rtl/rvr_req_sync.sv
module rvr_req_sync #(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_async,
  output logic [N_SRC-1:0] req_rise
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_SRC-1:0] stg [SYNC_STAGES];
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= req_async;
      for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
      prev_q <= stg[LAST];
    end
  end

  assign req_rise = stg[LAST] & ~prev_q;

  // R2
  rise_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise != '0) |=> ((req_rise & $past(req_rise)) == '0));
endmodule

// File: rtl/rvr_pend_arb.sv
module rvr_pend_arb
  import rvr_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_din,
  output logic             any_live,
  output lvl_t             win_lvl
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign live     = pend_q & ~mask_q;
  assign any_live = |live;

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (live[i]) win_lvl = lvl_t'(i);
    end
  end

  // R10
  pend_drop_only_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));
  // R6
  highest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_live |-> ((live >> win_lvl) == 1));
endmodule

// File: rtl/rvr_ack_ctl.sv
module rvr_ack_ctl
  import rvr_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n,
  input  logic             any_live,
  input  lvl_t             win_lvl,
  output logic [N_SRC-1:0] clr_vec,
  output logic             bus_oe,
  output logic [7:0]       bus_dout
);
  logic ack_q;
  logic held_vld_q;
  lvl_t held_lvl_q;
  logic ack_fall;
  logic ack_rise;
  lvl_t live_lvl;

  assign ack_fall = ack_q & ~ack_n;
  assign ack_rise = ~ack_q & ack_n;
  assign live_lvl = any_live ? win_lvl : lvl_t'(7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b1;
      held_vld_q <= 1'b0;
      held_lvl_q <= '0;
    end else begin
      ack_q <= ack_n;
      if (ack_fall) begin
        held_vld_q <= any_live;
        held_lvl_q <= live_lvl;
      end else if (ack_rise) begin
        held_vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    clr_vec = '0;
    if (ack_rise && held_vld_q) clr_vec[held_lvl_q] = 1'b1;
  end

  assign bus_oe   = ~ack_n;
  assign bus_dout = restart_op(ack_q ? live_lvl : held_lvl_q);

  // R9
  opcode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_q && !ack_n) |-> $stable(bus_dout));
  // R7
  opcode_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_dout[7:6] == 2'b11 && bus_dout[2:0] == 3'b111));
  // R10
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: rtl/rst_vec_responder.sv
module rst_vec_responder
  import rvr_pkg::*;
#(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] dev_req,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_din,
  input  logic             ack_n,
  output logic             irq_pull_low,
  output logic             bus_oe,
  output logic [7:0]       bus_dout
);
  logic [N_SRC-1:0] rise_vec;
  logic [N_SRC-1:0] clr_vec;
  logic             any_live;
  lvl_t             win_lvl;

  rvr_req_sync #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_async(dev_req), .req_rise(rise_vec));

  rvr_pend_arb #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_vec(rise_vec), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_din(mask_din), .any_live(any_live), .win_lvl(win_lvl));

  rvr_ack_ctl #(.N_SRC(N_SRC)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .any_live(any_live), .win_lvl(win_lvl),
    .clr_vec(clr_vec), .bus_oe(bus_oe), .bus_dout(bus_dout));

  assign irq_pull_low = any_live;

  // R8
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && $past(ack_n)) |-> !bus_oe);
endmodule

// File: tb/rst_vec_responder_test.sv
module rst_vec_responder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_req = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_din = '0;
  logic       ack_n = 1'b1;
  logic       irq_pull_low;
  logic       bus_oe;
  logic [7:0] bus_dout;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_vec_responder uut (.*);

  // {requests, mask, expected opcode, expected irq}
  localparam logic [24:0] VEC [8] = '{
    {8'h01, 8'h00, 8'hC7, 1'b1},
    {8'h80, 8'h00, 8'hFF, 1'b1},
    {8'h24, 8'h00, 8'hEF, 1'b1},
    {8'h24, 8'h20, 8'hD7, 1'b1},
    {8'h08, 8'h08, 8'hFF, 1'b0},
    {8'h52, 8'h40, 8'hE7, 1'b1},
    {8'hFF, 8'h00, 8'hFF, 1'b1},
    {8'h02, 8'h00, 8'hCF, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; dev_req = '0; ack_n = 1; mask_we = 0;
    clocks(2); rst_n = 1; clocks(1);
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_din = m; mask_we = 1; clocks(1); mask_we = 0;
  endtask

  task automatic pulse_req(input logic [7:0] r);
    dev_req = r; clocks(4); dev_req = '0; clocks(1);
  endtask

  // drive ack low, check opcode, release, check bus tri-stated
  task automatic ack_cycle(input string req, input logic [7:0] exp_op);
    ack_n = 0; #1;
    chk("R8 oe during ack", {7'd0, bus_oe}, 8'h01);
    clocks(1);
    chk(req, bus_dout, exp_op);
    clocks(1);
    ack_n = 1; #1;
    chk("R8 oe after ack", {7'd0, bus_oe}, 8'h00);
    clocks(1);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {7'd0, irq_pull_low}, 8'h00);
    chk("R1 oe", {7'd0, bus_oe}, 8'h00);

    for (int v = 0; v < 8; v++) begin
      do_reset();
      set_mask(VEC[v][16:9]);
      pulse_req(VEC[v][24:17]);
      chk("R3 irq level", {7'd0, irq_pull_low}, {7'd0, VEC[v][0]});
      ack_cycle("R6 R7 opcode", VEC[v][8:1]);
    end

    // R2 latency: pending within 4 edges
    do_reset();
    dev_req = 8'h10; clocks(4);
    chk("R2 latch latency", {7'd0, irq_pull_low}, 8'h01);
    // R2 held level does not re-latch after clear
    ack_cycle("R7 level4", 8'hE7);
    clocks(3);
    chk("R2 held level no relatch", {7'd0, irq_pull_low}, 8'h00);
    dev_req = '0; clocks(1);

    // R10 only acked bit cleared
    do_reset();
    pulse_req(8'h24);
    ack_cycle("R10 first", 8'hEF);
    chk("R10 other stays", {7'd0, irq_pull_low}, 8'h01);
    ack_cycle("R10 second", 8'hD7);
    chk("R10 all cleared", {7'd0, irq_pull_low}, 8'h00);

    // R4 masked pending retained, R5 mask timing
    do_reset();
    set_mask(8'h08);
    pulse_req(8'h08);
    chk("R4 masked no irq", {7'd0, irq_pull_low}, 8'h00);
    mask_din = 8'h00; mask_we = 1; @(posedge clk); #1; mask_we = 0;
    chk("R5 R4 unmask raises", {7'd0, irq_pull_low}, 8'h01);
    clocks(1);
    ack_cycle("R4 opcode", 8'hDF);
    chk("R4 cleared", {7'd0, irq_pull_low}, 8'h00);

    // R11 empty ack clears nothing (masked pending kept)
    do_reset();
    set_mask(8'h02);
    pulse_req(8'h02);
    ack_cycle("R11 empty opcode", 8'hFF);
    set_mask(8'h00);
    chk("R11 pending kept", {7'd0, irq_pull_low}, 8'h01);

    // R9 freeze during strobe
    do_reset();
    pulse_req(8'h04);
    ack_n = 0; clocks(1);
    dev_req = 8'h80; clocks(6);
    chk("R9 frozen opcode", bus_dout, 8'hD7);
    ack_n = 1; dev_req = '0; clocks(1);
    chk("R9 late still pending", {7'd0, irq_pull_low}, 8'h01);
    ack_cycle("R9 late wins", 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule